// File: doc/BRIEF.md
# State-Indexed Per-Bunch Damper Settings Store

This block keeps the damper's settings for every bunch slot of the ring, one complete bank of them for each machine state. As the beam passes, the bunch index is presented each cycle and the block returns that bunch's gain, damp or anti-damp sign, noise and ping enables, dead band and blow-out selections for X and Y, two cycles later. The arithmetic that applies these settings lives downstream.

The bank in use follows the machine-state input, but only at a revolution marker, so every turn is served from one bank. A host writes entries by state and bunch number through a single write port. Writes to a bank that is not in use land at once. Writes to the bank in use are held in a small queue and all land together at the next marker. The same port loads, per state, an inclusive turn window outside which anti-damping is suppressed.

Top module: `dmp_bunch_ctrl`

## Requirements
- R1: After reset the output valid is low, the bank in use is state 0, every stored entry reads as zero, and every state's anti-damp window is turns 0 to 0.
- R2: A lookup presented with idx_valid high in cycle t gives out_valid high and that bunch's fields in cycle t+2; a lookup with an index of NUM_BUNCH or more gives out_valid low.
- R3: An entry write (wr_kind 0) stores wr_data as: gain in bits 11:0 (two's complement), dead band in 19:12, anti-damp flag in 20, noise enable in 21, ping enable in 22, blow-out X in 23, blow-out Y in 24; bits 31:25 are ignored.
- R4: Entries are addressed by state and bunch together; a lookup returns the entry of the bank in use, never the same bunch of another state.
- R5: A change of mach_state has no effect until a cycle with rev_marker high; lookups presented in the marker cycle and after use the state sampled in that cycle.
- R6: An entry write to the bank in use outside a marker cycle is not visible to lookups until the next marker; lookups presented in that marker cycle already see it.
- R7: An entry write to any other bank is visible to lookups presented from the next cycle on.
- R8: At most PEND_DEPTH (default 4) writes to the bank in use are held between markers; further ones are dropped; an entry write in a marker cycle is applied at that marker.
- R9: Held writes to the same entry land in arrival order, so the latest one wins.
- R10: A window write (wr_kind 1) sets, for wr_state, the first turn from wr_data[15:0] and the last turn from wr_data[31:16]; out_anti is the stored anti-damp flag only when first <= turn_cnt <= last, and is never set when first > last.
- R11: Entry writes with a bunch number of NUM_BUNCH or more are ignored and alter no other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_kind | input | 1 | 0 entry write, 1 turn-window write |
| wr_state | input | clog2(NUM_STATE) | Bank written |
| wr_bunch | input | clog2(NUM_BUNCH) | Bunch written (entry writes) |
| wr_data | input | 32 | Entry word or window bounds |
| mach_state | input | clog2(NUM_STATE) | Current machine state |
| rev_marker | input | 1 | One-cycle revolution marker |
| idx_valid | input | 1 | Lookup request |
| bunch_idx | input | clog2(NUM_BUNCH) | Bunch looked up |
| turn_cnt | input | TURN_W | Turn number of the lookup |
| out_valid | output | 1 | Settings below are valid |
| out_gain | output | 12 | Signed gain |
| out_dead_band | output | 8 | Dead band |
| out_anti | output | 1 | Anti-damp (sign inverted) in force |
| out_noise | output | 1 | Noise injection enable |
| out_ping | output | 1 | Ping enable |
| out_blow_x | output | 1 | Blow-out in X |
| out_blow_y | output | 1 | Blow-out in Y |

## Verification
Directed sequences separate the write paths: a write to an idle bank must show on the next lookup, one to the bank in use must stay hidden until a marker, a fifth held write must vanish, and a state change without a marker must leave lookups untouched. Window lookups at the first turn, last turn and one either side, plus an inverted window, pin down the inclusive comparison. Aliasing is probed by an out-of-range bunch write that would hit bunch 0 of the next state if addresses wrapped. A long random mix of writes, windows, markers and lookups then runs against a bench model of banks, queue and windows.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

   // stored part of one per-bunch entry; upper host bits are not kept
   localparam int ENTRY_W = 25;
   localparam int GAIN_W  = 12;
   localparam int DB_W    = 8;

   typedef struct packed {
      logic              blow_y;
      logic              blow_x;
      logic              ping;
      logic              noise;
      logic              anti;
      logic [DB_W-1:0]   dead_band;
      logic [GAIN_W-1:0] gain;
   } dmp_entry_t;

   typedef enum logic {
      WK_ENTRY  = 1'b0,
      WK_WINDOW = 1'b1
   } dmp_wr_kind_e;

endpackage

// File: rtl/dmp_bank_sel.sv
module dmp_bank_sel #(
   parameter int NUM_STATE = 8,
   parameter int SW        = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rev_marker,
   input  logic [SW-1:0] mach_state,
   output logic [SW-1:0] active_bank,
   output logic [SW-1:0] lookup_bank
);
   localparam logic [SW:0] NS_L = (SW+1)'(NUM_STATE);

   logic state_ok;
   logic take;

   assign state_ok = {1'b0, mach_state} < NS_L;
   assign take     = rev_marker && state_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    active_bank <= '0;
      else if (take) active_bank <= mach_state;
   end

   // the marker cycle already belongs to the new turn
   assign lookup_bank = take ? mach_state : active_bank;
endmodule

// File: rtl/dmp_pend_buf.sv
module dmp_pend_buf #(
   parameter int DEPTH = 4,
   parameter int AW    = 10,
   parameter int DW    = 25,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          clear,
   output logic [CW-1:0] cnt,
   output logic [AW-1:0] e_addr [DEPTH],
   output logic [DW-1:0] e_data [DEPTH],
   output logic          e_vld  [DEPTH]
);
   localparam logic [CW-1:0] FULL_L = CW'(DEPTH);

   logic full;
   logic accept;

   assign full   = (cnt == FULL_L);
   assign accept = push && !full && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (accept) cnt <= cnt + 1'b1;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_addr[g] <= '0;
            e_data[g] <= '0;
         end else if (accept && cnt == CW'(g)) begin
            e_addr[g] <= push_addr;
            e_data[g] <= push_data;
         end
      end
      assign e_vld[g] = (cnt > CW'(g));
   end
endmodule

// File: rtl/dmp_set_ram.sv
module dmp_set_ram #(
   parameter int ENT            = 768,
   parameter int AW             = 10,
   parameter int DW             = 25,
   parameter int PEND_DEPTH     = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          drain,
   input  logic [AW-1:0] p_addr [PEND_DEPTH],
   input  logic [DW-1:0] p_data [PEND_DEPTH],
   input  logic          p_vld  [PEND_DEPTH],
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] mem [ENT];

   if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < ENT; i++) mem[i] <= '0;
         end else begin
            // held writes first, oldest first; a direct write wins last
            if (drain) begin
               for (int i = 0; i < PEND_DEPTH; i++)
                  if (p_vld[i]) mem[p_addr[i]] <= p_data[i];
            end
            if (wr_en) mem[wr_addr] <= wr_data;
         end
      end
   end else begin : g_noclr
      always_ff @(posedge clk) begin
         if (drain) begin
            for (int i = 0; i < PEND_DEPTH; i++)
               if (p_vld[i]) mem[p_addr[i]] <= p_data[i];
         end
         if (wr_en) mem[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/dmp_turn_window.sv
module dmp_turn_window #(
   parameter int NUM_STATE = 8,
   parameter int SW        = 3,
   parameter int TURN_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SW-1:0]     wr_state,
   input  logic [TURN_W-1:0] wr_first,
   input  logic [TURN_W-1:0] wr_last,
   input  logic [SW-1:0]     q_state,
   input  logic [TURN_W-1:0] q_turn,
   output logic              in_win
);
   logic [TURN_W-1:0] first_q [NUM_STATE];
   logic [TURN_W-1:0] last_q  [NUM_STATE];

   for (genvar s = 0; s < NUM_STATE; s++) begin : g_st
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            first_q[s] <= '0;
            last_q[s]  <= '0;
         end else if (wr_en && wr_state == SW'(s)) begin
            first_q[s] <= wr_first;
            last_q[s]  <= wr_last;
         end
      end
   end

   assign in_win = (q_turn >= first_q[q_state]) && (q_turn <= last_q[q_state]);
endmodule

// File: rtl/dmp_bunch_ctrl.sv
module dmp_bunch_ctrl #(
   parameter int NUM_BUNCH      = 96,
   parameter int NUM_STATE      = 8,
   parameter int PEND_DEPTH     = 4,
   parameter int TURN_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int SW  = (NUM_STATE > 1) ? $clog2(NUM_STATE) : 1,
   localparam int BW  = (NUM_BUNCH > 1) ? $clog2(NUM_BUNCH) : 1,
   localparam int ENT = NUM_STATE * NUM_BUNCH,
   localparam int AW  = $clog2(ENT),
   localparam int CW  = $clog2(PEND_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_kind,
   input  logic [SW-1:0]     wr_state,
   input  logic [BW-1:0]     wr_bunch,
   input  logic [31:0]       wr_data,
   input  logic [SW-1:0]     mach_state,
   input  logic              rev_marker,
   input  logic              idx_valid,
   input  logic [BW-1:0]     bunch_idx,
   input  logic [TURN_W-1:0] turn_cnt,
   output logic              out_valid,
   output logic signed [11:0] out_gain,
   output logic [7:0]        out_dead_band,
   output logic              out_anti,
   output logic              out_noise,
   output logic              out_ping,
   output logic              out_blow_x,
   output logic              out_blow_y
);
   import dmp_pkg::*;

   // elaboration-time parameter checks
   if (NUM_BUNCH < 2) begin : g_bad_nb
      $error("NUM_BUNCH must be at least 2");
   end
   if (NUM_STATE < 2) begin : g_bad_ns
      $error("NUM_STATE must be at least 2");
   end
   if (PEND_DEPTH < 1) begin : g_bad_pd
      $error("PEND_DEPTH must be at least 1");
   end
   if (TURN_W < 1 || 2 * TURN_W > 32) begin : g_bad_tw
      $error("TURN_W must fit twice in the 32-bit write word");
   end

   localparam logic [BW:0] NB_L = (BW+1)'(NUM_BUNCH);
   localparam logic [SW:0] NS_L = (SW+1)'(NUM_STATE);
   localparam logic [AW-1:0] NB_A = AW'(NUM_BUNCH);

   function automatic logic [AW-1:0] flat_addr(input logic [SW-1:0] st,
                                                input logic [BW-1:0] bn);
      return AW'(st) * NB_A + AW'(bn);
   endfunction

   // ---------------- bank selection
   logic [SW-1:0] active_bank;
   logic [SW-1:0] lookup_bank;

   dmp_bank_sel #(.NUM_STATE(NUM_STATE), .SW(SW)) u_bank (
      .clk(clk), .rst_n(rst_n), .rev_marker(rev_marker),
      .mach_state(mach_state), .active_bank(active_bank),
      .lookup_bank(lookup_bank)
   );

   // ---------------- write decode
   dmp_wr_kind_e  kind;
   logic          st_ok;
   logic          entry_wr;
   logic          hold_wr;
   logic          direct_wr;
   logic          win_wr;
   logic [AW-1:0] w_addr;
   logic [ENTRY_W-1:0] w_word;

   assign kind      = dmp_wr_kind_e'(wr_kind);
   assign st_ok     = {1'b0, wr_state} < NS_L;
   assign entry_wr  = wr_en && kind == WK_ENTRY && st_ok && ({1'b0, wr_bunch} < NB_L);
   assign hold_wr   = entry_wr && !rev_marker && (wr_state == active_bank);
   assign direct_wr = entry_wr && !hold_wr;
   assign win_wr    = wr_en && kind == WK_WINDOW && st_ok;
   assign w_addr    = flat_addr(wr_state, wr_bunch);
   assign w_word    = wr_data[ENTRY_W-1:0];

   // ---------------- held writes to the bank in use
   logic [CW-1:0]      pend_cnt;
   logic [AW-1:0]      pend_addr [PEND_DEPTH];
   logic [ENTRY_W-1:0] pend_data [PEND_DEPTH];
   logic               pend_vld  [PEND_DEPTH];

   dmp_pend_buf #(.DEPTH(PEND_DEPTH), .AW(AW), .DW(ENTRY_W), .CW(CW)) u_pend (
      .clk(clk), .rst_n(rst_n), .push(hold_wr), .push_addr(w_addr),
      .push_data(w_word), .clear(rev_marker), .cnt(pend_cnt),
      .e_addr(pend_addr), .e_data(pend_data), .e_vld(pend_vld)
   );

   // ---------------- lookup stage 1
   logic              s1_valid;
   logic [AW-1:0]     s1_addr;
   logic [SW-1:0]     s1_bank;
   logic [TURN_W-1:0] s1_turn;
   logic              idx_ok;

   assign idx_ok = idx_valid && ({1'b0, bunch_idx} < NB_L);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_addr  <= '0;
         s1_bank  <= '0;
         s1_turn  <= '0;
      end else begin
         s1_valid <= idx_ok;
         if (idx_ok) begin
            s1_addr <= flat_addr(lookup_bank, bunch_idx);
            s1_bank <= lookup_bank;
            s1_turn <= turn_cnt;
         end
      end
   end

   // ---------------- storage with registered read (stage 2)
   logic [ENTRY_W-1:0] rd_word;

   dmp_set_ram #(
      .ENT(ENT), .AW(AW), .DW(ENTRY_W), .PEND_DEPTH(PEND_DEPTH),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_ram (
      .clk(clk), .rst_n(rst_n), .drain(rev_marker),
      .p_addr(pend_addr), .p_data(pend_data), .p_vld(pend_vld),
      .wr_en(direct_wr), .wr_addr(w_addr), .wr_data(w_word),
      .rd_en(s1_valid), .rd_addr(s1_addr), .rd_data(rd_word)
   );

   // ---------------- anti-damp turn window
   logic in_win;
   logic win_q;

   dmp_turn_window #(.NUM_STATE(NUM_STATE), .SW(SW), .TURN_W(TURN_W)) u_win (
      .clk(clk), .rst_n(rst_n), .wr_en(win_wr), .wr_state(wr_state),
      .wr_first(wr_data[TURN_W-1:0]), .wr_last(wr_data[2*TURN_W-1:TURN_W]),
      .q_state(s1_bank), .q_turn(s1_turn), .in_win(in_win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         win_q     <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         win_q     <= in_win;
      end
   end

   // ---------------- output decode
   dmp_entry_t ent;
   assign ent = dmp_entry_t'(rd_word);

   assign out_gain      = ent.gain;
   assign out_dead_band = ent.dead_band;
   assign out_anti      = ent.anti && win_q;
   assign out_noise     = ent.noise;
   assign out_ping      = ent.ping;
   assign out_blow_x    = ent.blow_x;
   assign out_blow_y    = ent.blow_y;
endmodule

// File: rtl/dmp_bunch_ctrl_chk.sv
module dmp_bunch_ctrl_chk #(
   parameter int NUM_BUNCH  = 96,
   parameter int NUM_STATE  = 8,
   parameter int PEND_DEPTH = 4,
   parameter int SW         = 3,
   parameter int BW         = 7,
   parameter int CW         = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rev_marker,
   input logic [SW-1:0] mach_state,
   input logic          idx_valid,
   input logic [BW-1:0] bunch_idx,
   input logic          out_valid,
   input logic [SW-1:0] active_bank,
   input logic [CW-1:0] pend_cnt
);
   localparam logic [BW:0]   NB_L = (BW+1)'(NUM_BUNCH);
   localparam logic [SW:0]   NS_L = (SW+1)'(NUM_STATE);
   localparam logic [CW-1:0] PD_L = CW'(PEND_DEPTH);

   logic [1:0] age;
   logic       look_ok;
   logic       state_ok;

   assign look_ok  = idx_valid && ({1'b0, bunch_idx} < NB_L);
   assign state_ok = {1'b0, mach_state} < NS_L;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd2) age <= age + 1'b1;
   end

   // R2: a result appears exactly two cycles after an in-range lookup
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (out_valid == $past(look_ok, 2)));

   // R5: the bank in use never moves without a marker
   p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rev_marker |=> $stable(active_bank));

   // R5: a marker loads the sampled machine state
   p_bank_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rev_marker && state_ok) |=> (active_bank == $past(mach_state)));

   // R6: the marker empties the held writes
   p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rev_marker |=> (pend_cnt == '0));

   // R8: held writes never exceed the queue depth
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= PD_L);

   // R8: a full queue stays full until the next marker
   p_full_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rev_marker && pend_cnt == PD_L) |=> (pend_cnt == PD_L));
endmodule

bind dmp_bunch_ctrl dmp_bunch_ctrl_chk #(
   .NUM_BUNCH(NUM_BUNCH), .NUM_STATE(NUM_STATE), .PEND_DEPTH(PEND_DEPTH),
   .SW(SW), .BW(BW), .CW(CW)
) chk_i (
   .clk(clk), .rst_n(rst_n), .rev_marker(rev_marker), .mach_state(mach_state),
   .idx_valid(idx_valid), .bunch_idx(bunch_idx), .out_valid(out_valid),
   .active_bank(active_bank), .pend_cnt(pend_cnt)
);

// File: tb/dmp_bunch_ctrl_tb_top.sv
module dmp_bunch_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 96;
   localparam int NS = 8;
   localparam int PD = 4;
   localparam int SW = 3;
   localparam int BW = 7;
   localparam int TW = 16;
   localparam int WATCHDOG_CYC = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_kind = 1'b0;
   logic [SW-1:0] wr_state = '0;
   logic [BW-1:0] wr_bunch = '0;
   logic [31:0]   wr_data = '0;
   logic [SW-1:0] mach_state = '0;
   logic rev_marker = 1'b0, idx_valid = 1'b0;
   logic [BW-1:0] bunch_idx = '0;
   logic [TW-1:0] turn_cnt = '0;
   logic out_valid, out_anti, out_noise, out_ping, out_blow_x, out_blow_y;
   logic signed [11:0] out_gain;
   logic [7:0] out_dead_band;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmp_bunch_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
      .wr_state(wr_state), .wr_bunch(wr_bunch), .wr_data(wr_data),
      .mach_state(mach_state), .rev_marker(rev_marker), .idx_valid(idx_valid),
      .bunch_idx(bunch_idx), .turn_cnt(turn_cnt), .out_valid(out_valid),
      .out_gain(out_gain), .out_dead_band(out_dead_band), .out_anti(out_anti),
      .out_noise(out_noise), .out_ping(out_ping), .out_blow_x(out_blow_x),
      .out_blow_y(out_blow_y)
   );

   int n_chk = 0;
   int n_bad = 0;

   // ---------------- bench model
   logic [31:0] m_mem [NS][NB];
   logic [TW-1:0] m_first [NS];
   logic [TW-1:0] m_last  [NS];
   int m_bank = 0;
   int m_pcnt = 0;
   int m_ps [PD];
   int m_pb [PD];
   logic [31:0] m_pd [PD];

   // staged stimulus for the next cycle
   bit b_we = 0, b_wk = 0, b_mk = 0, b_le = 0;
   int b_ws = 0, b_wb = 0, b_ms = 0, b_lb = 0, b_lt = 0;
   logic [31:0] b_wd = '0;

   // two-deep expectation pipe
   bit p1_le = 0, p2_le = 0;
   logic [25:0] p1_exp = '0, p2_exp = '0;
   string p1_tag = "", p2_tag = "";

   // expected output word {valid, gain, dead band, anti, noise, ping, blow x, blow y}
   function automatic logic [25:0] expect_out(input int bk, input int bn, input int tn);
      logic [31:0] e;
      logic win;
      if (bn >= NB) return 26'd0;
      e = m_mem[bk][bn];
      win = (tn >= int'(m_first[bk])) && (tn <= int'(m_last[bk]));
      return {1'b1, e[11:0], e[19:12], e[20] & win, e[21], e[22], e[23], e[24]};
   endfunction

   task automatic check_pipe();
      logic [25:0] act;
      bit ok;
      act = {out_valid, out_gain, out_dead_band, out_anti, out_noise, out_ping,
             out_blow_x, out_blow_y};
      if (p2_le) begin
         n_chk++;
         ok = p2_exp[25] ? (act == p2_exp) : (out_valid == 1'b0);
         if (!ok) begin
            n_bad++;
            $display("FAIL %s: lookup result actual %h expected %h", p2_tag, act, p2_exp);
         end
      end
   endtask

   task automatic cyc(input string tag);
      check_pipe();
      wr_en      = b_we;
      wr_kind    = b_wk;
      wr_state   = SW'(b_ws);
      wr_bunch   = BW'(b_wb);
      wr_data    = b_wd;
      rev_marker = b_mk;
      mach_state = SW'(b_ms);
      idx_valid  = b_le;
      bunch_idx  = BW'(b_lb);
      turn_cnt   = TW'(b_lt);
      if (b_mk) begin
         for (int i = 0; i < m_pcnt; i++) m_mem[m_ps[i]][m_pb[i]] = m_pd[i];
         m_pcnt = 0;
         m_bank = b_ms;
      end
      if (b_we && !b_wk && b_wb < NB) begin
         if (!b_mk && b_ws == m_bank) begin
            if (m_pcnt < PD) begin
               m_ps[m_pcnt] = b_ws;
               m_pb[m_pcnt] = b_wb;
               m_pd[m_pcnt] = b_wd;
               m_pcnt++;
            end
         end else begin
            m_mem[b_ws][b_wb] = b_wd;
         end
      end
      if (b_we && b_wk) begin
         m_first[b_ws] = b_wd[15:0];
         m_last[b_ws]  = b_wd[31:16];
      end
      p2_le = p1_le; p2_exp = p1_exp; p2_tag = p1_tag;
      p1_le = b_le;
      p1_exp = b_le ? expect_out(m_bank, b_lb, b_lt) : 26'd0;
      p1_tag = tag;
      @(negedge clk);
      b_we = 0; b_mk = 0; b_le = 0;
   endtask

   task automatic wr_entry(input int s, input int b, input logic [31:0] d, input string tag);
      b_we = 1; b_wk = 0; b_ws = s; b_wb = b; b_wd = d;
      cyc(tag);
   endtask

   task automatic wr_win(input int s, input int first, input int last, input string tag);
      b_we = 1; b_wk = 1; b_ws = s; b_wb = 0; b_wd = {16'(last), 16'(first)};
      cyc(tag);
   endtask

   task automatic look(input int b, input int t, input string tag);
      b_le = 1; b_lb = b; b_lt = t;
      cyc(tag);
   endtask

   task automatic marker(input int s, input string tag);
      b_mk = 1; b_ms = s;
      cyc(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc("idle");
   endtask

   initial begin
      int seed_v;
      for (int s = 0; s < NS; s++) begin
         m_first[s] = '0;
         m_last[s]  = '0;
         for (int b = 0; b < NB; b++) m_mem[s][b] = '0;
      end
      seed_v = $urandom(32'h0D4A3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state at the ports
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: out_valid actual %b expected 0", out_valid);
      end
      look(5, 0, "R1");
      look(NB - 1, 0, "R1");

      // R7 and R4: write to an idle bank, bank in use unaffected
      wr_entry(3, 10, 32'hFE5A_B7C3, "R7");
      look(10, 0, "R4");
      marker(3, "R5");
      look(10, 0, "R3");
      wr_entry(3, 11, 32'h01FF_F800, "R3");
      marker(3, "R3");
      look(11, 0, "R3");

      // R5: state change without a marker is ignored
      b_ms = 5; cyc("R5");
      look(10, 0, "R5");
      look(10, 0, "R5");
      // marker with a lookup in the same cycle uses the new bank
      b_mk = 1; b_ms = 0; b_le = 1; b_lb = 10; b_lt = 0; cyc("R5");
      look(10, 0, "R5");
      marker(3, "R5");

      // R6: held write stays hidden until the marker
      wr_entry(3, 20, 32'h0012_3456, "R6");
      look(20, 0, "R6");
      idle(2);
      look(20, 0, "R6");
      b_mk = 1; b_ms = 3; b_le = 1; b_lb = 20; b_lt = 0; cyc("R6");
      look(20, 0, "R6");

      // R8: the queue holds PD writes, the next is dropped
      for (int i = 0; i < 5; i++) wr_entry(3, 30 + i, 32'h0000_0100 + 32'(i), "R8");
      for (int i = 0; i < 5; i++) look(30 + i, 0, "R8");
      marker(3, "R8");
      for (int i = 0; i < 5; i++) look(30 + i, 0, "R8");
      // a write in the marker cycle lands at that marker
      b_we = 1; b_wk = 0; b_ws = 3; b_wb = 34; b_wd = 32'h00AB_CDEF;
      b_mk = 1; b_ms = 3; cyc("R8");
      look(34, 0, "R8");

      // R9: latest held write to one entry wins
      wr_entry(3, 40, 32'h0000_0111, "R9");
      wr_entry(3, 40, 32'h0000_0222, "R9");
      marker(3, "R9");
      look(40, 0, "R9");

      // R10: window boundaries and an inverted window
      wr_entry(3, 50, 32'h0010_0005, "R10");
      marker(3, "R10");
      wr_win(3, 150, 350, "R10");
      look(50, 149, "R10");
      look(50, 150, "R10");
      look(50, 350, "R10");
      look(50, 351, "R10");
      wr_win(3, 300, 250, "R10");
      look(50, 260, "R10");
      look(50, 300, "R10");

      // R11: out-of-range write must not alias into the next state
      wr_entry(2, NB, 32'h00FF_FFFF, "R11");
      look(0, 0, "R11");
      marker(2, "R11");
      look(NB - 1, 0, "R11");
      marker(3, "R11");
      // R2: out-of-range lookups and back-to-back lookups
      look(NB, 0, "R2");
      look(127, 0, "R2");
      look(1, 0, "R2");
      look(2, 0, "R2");

      // constrained random mix
      for (int k = 0; k < 4000; k++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 25) begin
            b_we = 1; b_wk = ($urandom_range(0, 7) == 0);
            b_ws = int'($urandom_range(0, NS - 1));
            b_wb = int'($urandom_range(0, NB + 4));
            if (b_wk) b_wd = {16'($urandom_range(0, 400)), 16'($urandom_range(0, 400))};
            else      b_wd = $urandom;
         end
         if ($urandom_range(0, 19) == 0) b_ms = int'($urandom_range(0, NS - 1));
         if ($urandom_range(0, 39) == 0) b_mk = 1;
         if ($urandom_range(0, 1) == 0) begin
            b_le = 1;
            b_lb = int'($urandom_range(0, NB + 4));
            b_lt = int'($urandom_range(0, 400));
         end
         cyc("R4");
      end
      idle(3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule